// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a core's uncached store path and the memory fabric for an address region that tolerates write combining. Stores arriving on a narrow store port are gathered into a small pool of line-sized buffers, each bound to one 64-byte aligned line. Stores to a line that already owns a buffer merge into it, with a per-byte valid mask recording which bytes hold data. Each buffer leaves the block as one line-wide burst carrying that mask, so the fabric writes only the bytes that were stored.

A buffer is sent downstream in three cases. The first is when all 64 of its bytes have been written. The second is when a fence pulse demands that everything buffered be drained. The third is when a store needs a new buffer and all of them are taken, in which case the oldest allocated buffer is evicted as a partial line. The fence-done pulse tells the issuing core that every line buffered before the fence has been accepted downstream, so anything it issues next cannot overtake that data. The downstream port uses a valid/ready handshake. The store port stalls whenever a store cannot be placed.

Top module: `wcCombiner`

## Requirements
- R1: After reset, wrValid and fenceDone are low, and stReady is high for any store address.
- R2: A store whose 64-byte line has no open buffer opens a free buffer for that line and produces no downstream write on its own. Every store carries at least one set strobe bit.
- R3: A store to a line with an open buffer that is not queued for output merges into that buffer. Its bytes overwrite bytes stored earlier at the same offsets, and the merged line leaves as a single downstream write.
- R4: When the last missing byte of a buffer is written, that buffer is emitted without any further trigger, as one write with all 64 wrMask bits set.
- R5: A fenceReq pulse stalls the store port and drains every open buffer. When more than one buffer is waiting, they leave in the order they were opened. fenceDone pulses for one cycle once no buffer remains, and this is the cycle after the pulse if nothing was open.
- R6: A store to a new line while all NUM_BUF buffers are open and none is queued for output evicts the oldest opened buffer. That buffer is emitted as a partial write whose mask holds only its stored bytes. The store waits and then opens a buffer.
- R7: While wrValid is high and wrReady is low, wrValid stays high and wrAddr, wrData and wrMask stay unchanged.
- R8: Store address bits [5:3] select an 8-byte word of the line. Strobe bit j writes stData[8j+7:8j] to line byte 8*word+j. On output, wrData[8k+7:8k] is line byte k, wrMask bit k marks it written, and wrAddr is the line's byte address with bits [5:0] zero.
- R9: A store to a line whose buffer is queued for output is held off (stReady low) until that buffer is accepted. It then opens a new buffer rather than joining the outgoing one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store request present |
| stReady | output | 1 | Store accepted this cycle if stValid is high |
| stAddr | input | ADDR_W | Store byte address; bits [5:3] pick the word in the line |
| stData | input | 8*STORE_BYTES | Store data, byte j in bits [8j+7:8j] |
| stStrb | input | STORE_BYTES | Per-byte write strobes of the store |
| fenceReq | input | 1 | One-cycle request to drain all buffers |
| fenceDone | output | 1 | One-cycle pulse: the fence has drained |
| wrValid | output | 1 | Line write present |
| wrReady | input | 1 | Downstream accepts the line write |
| wrAddr | output | ADDR_W | Line-aligned byte address of the write |
| wrData | output | 8*LINE_BYTES | Line data, byte k in bits [8k+7:8k] |
| wrMask | output | LINE_BYTES | Per-byte valid mask of the line |

## Verification
The delicate overlap is a store that merges into or opens a buffer in the same cycle that a different buffer is accepted downstream. In that cycle one buffer frees its slot and the allocation order of the survivors shifts, while another buffer gains data or a position in that order. Randomized stores to six lines over four buffers, with downstream ready toggled at random, force this overlap often. The outcome is judged by rebuilding a byte image from the emitted writes and comparing it with a bench model of the stores. Directed eviction and fence sequences check the emission order.

// File: rtl/wcCombinerPkg.sv
package wcCombinerPkg;
  // wide enough for any supported pool size (up to 16 buffers)
  localparam int BUF_IDX_W = 4;

  typedef struct packed {
    logic                 wrEn;   // write the store into buffer wrIdx
    logic                 alloc;  // the write opens the buffer for a new line
    logic [BUF_IDX_W-1:0] wrIdx;
    logic [BUF_IDX_W-1:0] outIdx; // buffer presented on the line-write port
  } wcStrobe_t;
endpackage

// File: rtl/wcCombinerData.sv
module wcCombinerData
  import wcCombinerPkg::*;
#(
  parameter int NUM_BUF     = 4,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int STORE_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wcStrobe_t                 str,
  input  logic [ADDR_W-1:0]         stAddr,
  input  logic [8*STORE_BYTES-1:0]  stData,
  input  logic [STORE_BYTES-1:0]    stStrb,
  input  logic                      wrValid,
  output logic [NUM_BUF-1:0]        matchVec,
  output logic [NUM_BUF-1:0]        fillOnMerge,
  output logic                      fillOnAlloc,
  output logic [ADDR_W-1:0]         wrAddr,
  output logic [8*LINE_BYTES-1:0]   wrData,
  output logic [LINE_BYTES-1:0]     wrMask
);
  localparam int LINE_OFF_W = $clog2(LINE_BYTES);
  localparam int WORD_OFF_W = $clog2(STORE_BYTES);
  localparam int TAG_W      = ADDR_W - LINE_OFF_W;
  localparam int WIDX_W     = LINE_OFF_W - WORD_OFF_W;

  logic [TAG_W-1:0]          stTag;
  logic [WIDX_W-1:0]         wordIdx;
  logic [LINE_BYTES-1:0]     stLineMask;
  logic [8*LINE_BYTES-1:0]   stLineData;
  logic [WORD_OFF_W-1:0]     unusedLowBits;

  assign stTag         = stAddr[ADDR_W-1:LINE_OFF_W];
  assign wordIdx       = stAddr[LINE_OFF_W-1:WORD_OFF_W];
  assign unusedLowBits = stAddr[WORD_OFF_W-1:0];
  assign stLineMask    = LINE_BYTES'(stStrb) << (int'(wordIdx) * STORE_BYTES);
  assign stLineData    = (8*LINE_BYTES)'(stData) << (int'(wordIdx) * 8 * STORE_BYTES);
  assign fillOnAlloc   = &stLineMask;

  logic [TAG_W-1:0]        tagQ  [NUM_BUF];
  logic [LINE_BYTES-1:0]   maskQ [NUM_BUF];
  logic [8*LINE_BYTES-1:0] dataQ [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBuf
    logic hitMe;
    assign hitMe          = str.wrEn && (str.wrIdx == BUF_IDX_W'(g));
    assign matchVec[g]    = (tagQ[g] == stTag);
    assign fillOnMerge[g] = &(maskQ[g] | stLineMask);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[g]  <= '0;
        maskQ[g] <= '0;
        dataQ[g] <= '0;
      end else if (hitMe) begin
        if (str.alloc) begin
          tagQ[g]  <= stTag;
          maskQ[g] <= stLineMask;
        end else begin
          maskQ[g] <= maskQ[g] | stLineMask;
        end
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (stLineMask[b]) dataQ[g][8*b +: 8] <= stLineData[8*b +: 8];
        end
      end
    end
  end

  // output mux over the buffer chosen by the control
  always_comb begin
    wrAddr = '0;
    wrData = '0;
    wrMask = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (str.outIdx == BUF_IDX_W'(i)) begin
        wrAddr = {tagQ[i], LINE_OFF_W'(0)};
        wrData = dataQ[i];
        wrMask = maskQ[i];
      end
    end
  end

  // R6: any emitted line, partial or full, carries at least one written byte
  p_mask_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrMask != '0));
endmodule

// File: rtl/wcCombinerCtrl.sv
module wcCombinerCtrl
  import wcCombinerPkg::*;
#(
  parameter int NUM_BUF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stValid,
  output logic               stReady,
  input  logic               fenceReq,
  output logic               fenceDone,
  output logic               wrValid,
  input  logic               wrReady,
  input  logic [NUM_BUF-1:0] matchVec,
  input  logic [NUM_BUF-1:0] fillOnMerge,
  input  logic               fillOnAlloc,
  output wcStrobe_t          str
);
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int CNT_W = IDX_W + 1;

  logic [NUM_BUF-1:0] validQ, pendQ;
  logic [IDX_W-1:0]   rankQ [NUM_BUF];   // 0 = oldest open buffer
  logic               fenceBusyQ, holdQ;
  logic [IDX_W-1:0]   holdIdxQ;

  logic [NUM_BUF-1:0] pendEff, hitVec;
  logic               hit, hitPend, anyFree, anyPend, found;
  logic [IDX_W-1:0]   hitIdx, freeIdx, bestIdx, outIdx, wrIdx, bestRank, newRank;
  logic [CNT_W-1:0]   validCount;
  logic               accept, doStore, evictReq, fillNow;

  always_comb begin
    pendEff  = pendQ | (validQ & {NUM_BUF{fenceBusyQ}});
    hitVec   = matchVec & validQ;
    hit      = |hitVec;
    hitPend  = |(hitVec & pendEff);
    anyFree  = ~&validQ;
    anyPend  = |pendEff;
    hitIdx   = '0;
    freeIdx  = '0;
    validCount = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (hitVec[i])  hitIdx  = IDX_W'(i);
      if (!validQ[i]) freeIdx = IDX_W'(i);
      validCount = validCount + CNT_W'(validQ[i]);
    end
    // lowest allocation rank among buffers waiting to leave
    found    = 1'b0;
    bestIdx  = '0;
    bestRank = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (pendEff[i] && (!found || rankQ[i] < bestRank)) begin
        found    = 1'b1;
        bestRank = rankQ[i];
        bestIdx  = IDX_W'(i);
      end
    end
    outIdx    = holdQ ? holdIdxQ : bestIdx;
    wrValid   = anyPend;
    accept    = wrValid && wrReady;
    stReady   = !fenceBusyQ && (hit ? !hitPend : anyFree);
    doStore   = stValid && stReady;
    evictReq  = stValid && !fenceBusyQ && !hit && !anyFree && !anyPend;
    wrIdx     = hit ? hitIdx : freeIdx;
    fillNow   = hit ? fillOnMerge[hitIdx] : fillOnAlloc;
    newRank   = IDX_W'(validCount - CNT_W'(accept));
    fenceDone = fenceBusyQ && (validQ == '0);
    str.wrEn   = doStore;
    str.alloc  = !hit;
    str.wrIdx  = BUF_IDX_W'(wrIdx);
    str.outIdx = BUF_IDX_W'(outIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ     <= '0;
      pendQ      <= '0;
      fenceBusyQ <= 1'b0;
      holdQ      <= 1'b0;
      holdIdxQ   <= '0;
      for (int i = 0; i < NUM_BUF; i++) rankQ[i] <= '0;
    end else begin
      fenceBusyQ <= fenceReq || (fenceBusyQ && !fenceDone);
      holdQ      <= wrValid && !wrReady;
      holdIdxQ   <= outIdx;
      for (int i = 0; i < NUM_BUF; i++) begin
        if (accept && outIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b0;
          pendQ[i]  <= 1'b0;
        end else begin
          if (validQ[i] && accept && rankQ[i] > rankQ[outIdx])
            rankQ[i] <= rankQ[i] - 1'b1;
          if ((evictReq && validQ[i] && rankQ[i] == '0) || (fenceBusyQ && validQ[i]))
            pendQ[i] <= 1'b1;
          if (doStore && wrIdx == IDX_W'(i)) begin
            if (!hit) begin
              validQ[i] <= 1'b1;
              rankQ[i]  <= newRank;
              pendQ[i]  <= fillNow;
            end else if (fillNow) begin
              pendQ[i] <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R6: a blocked new-line store puts a victim on the output next cycle
  p_evict_emits_r6: assert property (@(posedge clk) disable iff (!rstN)
    evictReq |=> wrValid);

  // R5: once the fence reports done, nothing from before it is left to send
  p_fence_drained_r5: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |=> !wrValid);

  // R9: a store is never written into a buffer already queued for output
  p_no_join_outgoing_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doStore && hit) |-> !pendQ[hitIdx]);
endmodule

// File: rtl/wcCombiner.sv
module wcCombiner
  import wcCombinerPkg::*;
#(
  parameter int NUM_BUF     = 4,   // 4 to 10
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int STORE_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stValid,
  output logic                     stReady,
  input  logic [ADDR_W-1:0]        stAddr,
  input  logic [8*STORE_BYTES-1:0] stData,
  input  logic [STORE_BYTES-1:0]   stStrb,
  input  logic                     fenceReq,
  output logic                     fenceDone,
  output logic                     wrValid,
  input  logic                     wrReady,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [8*LINE_BYTES-1:0]  wrData,
  output logic [LINE_BYTES-1:0]    wrMask
);
  wcStrobe_t          str;
  logic [NUM_BUF-1:0] matchVec, fillOnMerge;
  logic               fillOnAlloc;

  wcCombinerCtrl #(.NUM_BUF(NUM_BUF)) uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .fenceReq(fenceReq), .fenceDone(fenceDone), .wrValid(wrValid),
    .wrReady(wrReady), .matchVec(matchVec), .fillOnMerge(fillOnMerge),
    .fillOnAlloc(fillOnAlloc), .str(str)
  );

  wcCombinerData #(
    .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES), .STORE_BYTES(STORE_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .str(str), .stAddr(stAddr), .stData(stData),
    .stStrb(stStrb), .wrValid(wrValid), .matchVec(matchVec),
    .fillOnMerge(fillOnMerge), .fillOnAlloc(fillOnAlloc),
    .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask)
  );

  // R7: a stalled line write holds its content until accepted
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrMask) && $stable(wrData)));
endmodule

// File: tb/wcCombiner_test.sv
module wcCombiner_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stValid = 1'b0;
  logic         stReady;
  logic [31:0]  stAddr = BASE;
  logic [63:0]  stData = '0;
  logic [7:0]   stStrb = '0;
  logic         fenceReq = 1'b0;
  logic         fenceDone;
  logic         wrValid;
  logic         wrReady = 1'b1;
  logic [31:0]  wrAddr;
  logic [511:0] wrData;
  logic [63:0]  wrMask;

  wcCombiner uut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stStrb(stStrb),
    .fenceReq(fenceReq), .fenceDone(fenceDone), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int flushCnt = 0;
  int badAlign = 0;
  bit randReady = 1'b0;
  bit readyFixed = 1'b1;
  logic [7:0]  expMem [16][64];
  logic [7:0]  gotMem [16][64];
  logic [31:0] logAddr [256];
  logic [63:0] logMask [256];

  function automatic logic [31:0] lineAddr(input int slot);
    return BASE + 32'(slot) * 32'd64;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) wrReady <= randReady ? ($urandom % 4 != 0) : readyFixed;

  // downstream monitor, sampled well before the next rising edge
  always @(negedge clk) begin
    #2;
    if (rstN && wrValid && wrReady) begin
      int slot;
      slot = int'((wrAddr - BASE) >> 6) & 15;
      if (wrAddr[5:0] != 6'd0) badAlign++;
      for (int b = 0; b < 64; b++)
        if (wrMask[b]) gotMem[slot][b] = wrData[8*b +: 8];
      logAddr[flushCnt & 255] = wrAddr;
      logMask[flushCnt & 255] = wrMask;
      flushCnt++;
    end
  end

  task automatic doStore(input logic [31:0] addr, input logic [63:0] data, input logic [7:0] strb);
    int slot, word;
    @(negedge clk);
    stAddr = addr; stData = data; stStrb = strb; stValid = 1'b1;
    forever begin
      #1;
      if (stReady) break;
      @(negedge clk);
    end
    @(posedge clk);
    slot = int'((addr - BASE) >> 6) & 15;
    word = int'(addr[5:3]);
    for (int j = 0; j < 8; j++)
      if (strb[j]) expMem[slot][8*word + j] = data[8*j +: 8];
    #1 stValid = 1'b0;
  endtask

  task automatic doFence(output int polls);
    @(negedge clk);
    fenceReq = 1'b1;
    @(posedge clk);
    #1 fenceReq = 1'b0;
    polls = 0;
    forever begin
      @(negedge clk);
      #3;
      polls++;
      if (fenceDone) break;
    end
  endtask

  function automatic int lineDiffs(input int slot);
    int n = 0;
    for (int b = 0; b < 64; b++) if (gotMem[slot][b] !== expMem[slot][b]) n++;
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int polls, mark;
    logic [31:0] heldAddr;
    logic [63:0] expMask;
    for (int s = 0; s < 16; s++)
      for (int b = 0; b < 64; b++) begin expMem[s][b] = 8'h00; gotMem[s][b] = 8'h00; end
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(wrValid == 1'b0, "R1", "wrValid after reset", 64'(wrValid), 64'd0);
    check(fenceDone == 1'b0, "R1", "fenceDone after reset", 64'(fenceDone), 64'd0);
    check(stReady == 1'b1, "R1", "stReady after reset", 64'(stReady), 64'd1);

    // R2: a lone store opens a buffer and sends nothing
    mark = flushCnt;
    doStore(lineAddr(0) + 32'd16, 64'h1122_3344_5566_7788, 8'h3C);
    repeat (5) @(negedge clk);
    #3;
    check(flushCnt == mark, "R2", "writes after single store", 64'(flushCnt - mark), 64'd0);
    check(wrValid == 1'b0, "R2", "wrValid idle", 64'(wrValid), 64'd0);
    doFence(polls);

    // R3 + R8: merge with overwrite, single write
    mark = flushCnt;
    doStore(lineAddr(1) + 32'd0, 64'hA1A2_A3A4_A5A6_A7A8, 8'hFF);
    doStore(lineAddr(1) + 32'd8, 64'hB1B2_B3B4_B5B6_B7B8, 8'h0F);
    doStore(lineAddr(1) + 32'd0, 64'hC1C2_C3C4_C5C6_C7C8, 8'hF0);
    doFence(polls);
    check(flushCnt == mark + 1, "R3", "writes for merged line", 64'(flushCnt - mark), 64'd1);
    check(logMask[mark & 255] == 64'h0000_0000_0000_0FFF, "R3", "merged mask",
          logMask[mark & 255], 64'h0FFF);
    check(logAddr[mark & 255] == lineAddr(1), "R8", "merged line address",
          64'(logAddr[mark & 255]), 64'(lineAddr(1)));
    check(lineDiffs(1) == 0, "R3", "merged line bytes", 64'(lineDiffs(1)), 64'd0);

    // R4: full line leaves on its own
    mark = flushCnt;
    for (int w = 0; w < 8; w++)
      doStore(lineAddr(7) + 32'(8 * w), {8{8'(w + 8'h40)}}, 8'hFF);
    repeat (3) @(negedge clk);
    #3;
    check(flushCnt == mark + 1, "R4", "writes for full line", 64'(flushCnt - mark), 64'd1);
    check(logMask[mark & 255] == '1, "R4", "full mask", logMask[mark & 255], '1);
    check(lineDiffs(7) == 0, "R8", "full line bytes", 64'(lineDiffs(7)), 64'd0);

    // R6 + R5: eviction of the oldest, then fence order
    mark = flushCnt;
    for (int s = 2; s < 6; s++)
      doStore(lineAddr(s) + 32'(8 * (s - 2)), {8{8'(s)}}, 8'h81);
    check(flushCnt == mark, "R6", "no write while buffers spare", 64'(flushCnt - mark), 64'd0);
    doStore(lineAddr(6) + 32'd24, 64'hDEAD_BEEF_0BAD_F00D, 8'h01);
    check(flushCnt == mark + 1, "R6", "evictions", 64'(flushCnt - mark), 64'd1);
    check(logAddr[mark & 255] == lineAddr(2), "R6", "victim line",
          64'(logAddr[mark & 255]), 64'(lineAddr(2)));
    check(logMask[mark & 255] == 64'h81, "R6", "victim partial mask", logMask[mark & 255], 64'h81);
    doFence(polls);
    check(flushCnt == mark + 5, "R5", "writes drained by fence", 64'(flushCnt - mark), 64'd5);
    for (int k = 1; k < 5; k++)
      check(logAddr[(mark + k) & 255] == lineAddr(k + 2), "R5", "fence drain order",
            64'(logAddr[(mark + k) & 255]), 64'(lineAddr(k + 2)));
    check(logMask[(mark + 4) & 255] == 64'h0100_0000, "R8", "store word placement",
          logMask[(mark + 4) & 255], 64'h0100_0000);

    // R5: fence with nothing open
    doFence(polls);
    check(polls == 1, "R5", "empty fence latency", 64'(polls), 64'd1);

    // R7 + R9: backpressure hold, then store to the outgoing line
    readyFixed = 1'b0;
    repeat (2) @(negedge clk);
    mark = flushCnt;
    for (int w = 0; w < 8; w++)
      doStore(lineAddr(14) + 32'(8 * w), {8{8'(w + 8'h70)}}, 8'hFF);
    @(negedge clk);
    #3;
    heldAddr = wrAddr;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #3;
      check(wrValid == 1'b1 && wrAddr == heldAddr, "R7", "held line write",
            {31'd0, wrValid, wrAddr}, {31'd0, 1'b1, heldAddr});
    end
    @(negedge clk);
    stAddr = lineAddr(14) + 32'd40; stStrb = 8'h02; stData = 64'h0000_0000_0000_5A00; stValid = 1'b1;
    #1;
    check(stReady == 1'b0, "R9", "store to outgoing line stalls", 64'(stReady), 64'd0);
    stValid = 1'b0;
    readyFixed = 1'b1;
    doStore(lineAddr(14) + 32'd40, 64'h0000_0000_0000_5A00, 8'h02);
    doFence(polls);
    expMask = 64'h0000_0200_0000_0000;
    check(flushCnt == mark + 2, "R9", "writes for reopened line", 64'(flushCnt - mark), 64'd2);
    check(logMask[(mark + 1) & 255] == expMask, "R9", "reopened line mask",
          logMask[(mark + 1) & 255], expMask);
    check(lineDiffs(14) == 0, "R9", "reopened line bytes", 64'(lineDiffs(14)), 64'd0);

    // random mix over six lines, random backpressure
    randReady = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int slot;
      logic [7:0] strb;
      slot = 8 + int'($urandom % 6);
      strb = 8'($urandom);
      if (strb == 8'h00) strb = 8'h01;
      doStore(lineAddr(slot) + 32'(8 * ($urandom % 8)), {$urandom, $urandom}, strb);
      if ($urandom % 25 == 0) doFence(polls);
    end
    doFence(polls);
    randReady = 1'b0;
    for (int s = 8; s < 14; s++)
      check(lineDiffs(s) == 0, "R3", "random line image", 64'(lineDiffs(s)), 64'd0);
    check(badAlign == 0, "R8", "line-aligned addresses", 64'(badAlign), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule